// File: doc/BRIEF.md
# Learned MAC Address Table with Command Engine

This block holds the learned-address table of a small multi-port Ethernet switch and runs the maintenance commands a host issues through four 32-bit registers. A learn port adds entries. Each entry has a 48-bit MAC address, a destination port bitmask and a 4-bit status. Status 0 means the slot is empty, status 0xF means the entry is static, and any value in between is a dynamic entry that ages.

The host writes an operation code with the start bit set and polls that bit until the hardware clears it. Three operations are supported:
- Flush the whole table.
- Flush the unicast entries that reach one port.
- Get-next, which walks the table.

Get-next keeps no state between commands. The MAC address currently held in the address fields is the cursor. Each command reports the entry that follows the entry holding that MAC, so a host walks the table by re-issuing get-next with nothing rewritten. The command engine visits one table slot per cycle in index order.

Top module: `mac_table_engine`

## Requirements
- R1: After reset, all four registers read zero, `lrn_ready` is 1 and the table is empty.
- R2: Writing the command register (index 0) with bit 3 set while idle starts the operation in bits 2:0. Bit 3 reads 1 until the operation ends, and it clears at most 16 cycles after the write.
- R3: While bit 3 is set, any register write has no effect and `lrn_ready` is 0.
- R4: Get-next (op 6) with an all-zero cursor returns the valid entry with the lowest index. The entry's MAC has byte 0 as its most significant octet. MAC bytes 0..3 appear in register 1 at bits 31:24, 23:16, 15:8 and 7:0. Bytes 4 and 5 appear in command bits 23:16 and 31:24. The port bitmask appears in register 2 bits 4:0 and the status in register 2 bits 19:16.
- R5: Get-next with a non-zero cursor returns the lowest-index valid entry after the entry whose MAC equals the cursor. When no such entry exists, register 2 reads zero and the address fields are left unchanged.
- R6: When the cursor MAC is not in the table, get-next reports end of table (register 2 reads zero).
- R7: Flush-all (op 1) empties every slot.
- R8: Flush-port (op 3) empties only the entries whose MAC is unicast (bit 0 of byte 0 clear) and whose bitmask includes the port in command bits 11:8. Port numbers at or above the port count match nothing.
- R9: A learn of a new MAC fills the lowest empty slot. A learn of a MAC already present rewrites that entry's bitmask and status in place. Dynamic entries are written with status NEW_STATUS (default 7); static learns are written with 0xF.
- R10: With replacement off (control bit 18 = 0) and no empty slot, a learn is dropped and command bit 12 becomes 1. Bit 12 stays 1 until a command-register write has bit 12 set.
- R11: With replacement on and no empty slot, a learn overwrites the dynamic entry with the lowest status (lowest index on a tie). If every entry is static, the learn is dropped as in R10.
- R12: With control bit 17 set and age time T (bits 15:0) non-zero, every T×AGE_DIV cycles each dynamic status decrements by one. An entry whose status reaches 0 leaves the table. Static entries never change.
- R13: The control register (index 3) stores bits 15:0, 17, 18 and 20; every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write index: 0 command, 1 address, 2 result, 3 control |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read index |
| reg_rdata | output | 32 | Read data (combinational) |
| lrn_valid | input | 1 | Learn request |
| lrn_ready | output | 1 | Learn accepted this cycle when high |
| lrn_mac | input | 48 | MAC address to learn, byte 0 in bits 47:40 |
| lrn_ports | input | NPORTS | Destination port bitmask |
| lrn_static | input | 1 | Learn as a static entry |

## Verification
The hardest state to reach from the ports is a full table that mixes static and dynamic entries, with replacement switched on and off between learns. Only in that state do the victim choice, the drop and the sticky violation bit all come into play.

The stimulus reaches it with seeded random rounds. Each round learns more MACs than there are slots, re-learns some existing MACs, makes a fraction of them static or multicast, and toggles replacement. After every round a full get-next walk is compared against a bench model.

Directed cases cover three further situations:
- a cursor that is absent from the table;
- a flush on an out-of-range port, which keeps the engine busy for a full scan while writes are attempted;
- aging with a mix of static and dynamic entries.

// File: rtl/mat_pkg.sv
package mat_pkg;
   typedef enum logic [1:0] {
      RA_CMD    = 2'd0,
      RA_ADDR   = 2'd1,
      RA_RESULT = 2'd2,
      RA_CTRL   = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      OP_IDLE       = 3'd0,
      OP_FLUSH_ALL  = 3'd1,
      OP_FLUSH_PORT = 3'd3,
      OP_GET_NEXT   = 3'd6
   } op_e;

   localparam int CMD_BUSY_BIT = 3;
   localparam int CMD_VIOL_BIT = 12;
   localparam int CTL_AGE_EN   = 17;
   localparam int CTL_REPL_EN  = 18;
   localparam logic [31:0] CTL_MASK  = 32'h0016_FFFF;
   localparam logic [3:0]  ST_EMPTY  = 4'h0;
   localparam logic [3:0]  ST_STATIC = 4'hF;
endpackage

// File: rtl/mat_age_timer.sv
module mat_age_timer #(
   parameter int AGE_DIV = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic [15:0] age_time,
   output logic        tick
);
   localparam int DIV_W = (AGE_DIV > 2) ? $clog2(AGE_DIV) : 1;

   if (AGE_DIV < 2) begin : g_bad_div
      $error("mat_age_timer: AGE_DIV must be at least 2");
   end

   logic [DIV_W-1:0] pre_q;
   logic [15:0]      unit_q;
   logic             pre_wrap;
   logic             unit_wrap;

   assign pre_wrap  = (pre_q == DIV_W'(AGE_DIV - 1));
   assign unit_wrap = ({1'b0, unit_q} + 17'd1) >= {1'b0, age_time};
   assign tick      = en && (age_time != 16'd0) && pre_wrap && unit_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         unit_q <= '0;
      end else if (!en) begin
         pre_q  <= '0;
         unit_q <= '0;
      end else if (pre_wrap) begin
         pre_q  <= '0;
         unit_q <= unit_wrap ? 16'd0 : unit_q + 16'd1;
      end else begin
         pre_q <= pre_q + DIV_W'(1);
      end
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R12
endmodule

// File: rtl/mat_learn_select.sv
module mat_learn_select #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [47:0]    key,
   input  logic [47:0]    mac [N],
   input  logic [3:0]     st  [N],
   output logic           hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic           free_any,
   output logic [IDX_W-1:0] free_idx,
   output logic           vict_any,
   output logic [IDX_W-1:0] vict_idx
);
   import mat_pkg::*;

   logic [N-1:0] is_hit;
   logic [N-1:0] is_free;
   logic [N-1:0] is_dyn;

   for (genvar g = 0; g < N; g++) begin : g_flags
      assign is_free[g] = (st[g] == ST_EMPTY);
      assign is_hit[g]  = !is_free[g] && (mac[g] == key);
      assign is_dyn[g]  = !is_free[g] && (st[g] != ST_STATIC);
   end

   always_comb begin
      hit      = 1'b0;
      hit_idx  = '0;
      free_any = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (is_hit[i]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
         if (is_free[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      logic [3:0] best;
      best     = ST_STATIC;
      vict_any = 1'b0;
      vict_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (is_dyn[i] && (st[i] < best)) begin
            best     = st[i];
            vict_any = 1'b1;
            vict_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine #(
   parameter int ENTRIES    = 16,
   parameter int NPORTS     = 5,
   parameter int AGE_DIV    = 4,
   parameter int NEW_STATUS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [1:0]        reg_raddr,
   output logic [31:0]       reg_rdata,
   input  logic              lrn_valid,
   output logic              lrn_ready,
   input  logic [47:0]       lrn_mac,
   input  logic [NPORTS-1:0] lrn_ports,
   input  logic              lrn_static
);
   import mat_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int CNT_W = IDX_W + 2;

   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $error("mac_table_engine: ENTRIES out of range");
   end
   if (NPORTS < 1 || NPORTS > 5) begin : g_bad_ports
      $error("mac_table_engine: NPORTS must be 1..5");
   end
   if (NEW_STATUS < 1 || NEW_STATUS > 14) begin : g_bad_status
      $error("mac_table_engine: NEW_STATUS must be 1..14");
   end

   // table storage
   logic [47:0]       tbl_mac   [ENTRIES];
   logic [NPORTS-1:0] tbl_ports [ENTRIES];
   logic [3:0]        tbl_st    [ENTRIES];

   // host-visible state
   logic [2:0]  op_q;
   logic        busy_q;
   logic [3:0]  port_q;
   logic        viol_q;
   logic [7:0]  b4_q, b5_q;
   logic [31:0] addr_q;
   logic [4:0]  res_ports_q;
   logic [3:0]  res_st_q;
   logic [31:0] ctrl_q;

   // engine state
   logic [IDX_W-1:0] idx_q;
   logic             passed_q;
   logic             age_pend_q;

   logic [47:0] cursor;
   logic [47:0] start_cursor;
   logic        wr_idle;
   logic        start_cmd;

   assign cursor       = {addr_q, b4_q, b5_q};
   assign start_cursor = {addr_q, reg_wdata[23:16], reg_wdata[31:24]};
   assign wr_idle      = reg_we && !busy_q;
   assign start_cmd    = wr_idle && (reg_waddr == RA_CMD) && reg_wdata[CMD_BUSY_BIT];
   assign lrn_ready    = !busy_q;

   // entry under scan
   logic [47:0]       e_mac;
   logic [NPORTS-1:0] e_ports;
   logic [3:0]        e_st;
   logic              e_valid;
   logic [7:0]        e_pm8;
   logic              e_port_hit;
   logic              last;
   logic              scan_clear;

   assign e_mac      = tbl_mac[idx_q];
   assign e_ports    = tbl_ports[idx_q];
   assign e_st       = tbl_st[idx_q];
   assign e_valid    = (e_st != ST_EMPTY);
   assign e_pm8      = 8'(e_ports);
   assign e_port_hit = (port_q < 4'(NPORTS)) && e_pm8[port_q[2:0]];
   assign last       = (idx_q == IDX_W'(ENTRIES - 1));
   assign scan_clear = busy_q && ((op_q == OP_FLUSH_ALL) ||
                       ((op_q == OP_FLUSH_PORT) && e_valid && !e_mac[40] && e_port_hit));

   // learn slot choice
   logic             sel_hit, sel_free, sel_vict;
   logic [IDX_W-1:0] hit_idx, free_idx, vict_idx;
   logic             ins_drop;
   logic             ins_do;
   logic [IDX_W-1:0] ins_idx;

   mat_learn_select #(.N(ENTRIES), .IDX_W(IDX_W)) i_select (
      .key      (lrn_mac),
      .mac      (tbl_mac),
      .st       (tbl_st),
      .hit      (sel_hit),
      .hit_idx  (hit_idx),
      .free_any (sel_free),
      .free_idx (free_idx),
      .vict_any (sel_vict),
      .vict_idx (vict_idx)
   );

   always_comb begin
      ins_drop = 1'b0;
      if (sel_hit)                                ins_idx = hit_idx;
      else if (sel_free)                          ins_idx = free_idx;
      else if (ctrl_q[CTL_REPL_EN] && sel_vict)   ins_idx = vict_idx;
      else begin
         ins_idx  = '0;
         ins_drop = 1'b1;
      end
   end
   assign ins_do = lrn_valid && !busy_q && !ins_drop;

   // aging
   logic age_tick;

   mat_age_timer #(.AGE_DIV(AGE_DIV)) i_age (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q[CTL_AGE_EN]),
      .age_time (ctrl_q[15:0]),
      .tick     (age_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_pend_q <= 1'b0;
      else        age_pend_q <= age_tick || (age_pend_q && busy_q);
   end

   // table update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            tbl_mac[i]   <= '0;
            tbl_ports[i] <= '0;
            tbl_st[i]    <= ST_EMPTY;
         end
      end else if (busy_q) begin
         if (scan_clear) tbl_st[idx_q] <= ST_EMPTY;
      end else begin
         if (age_pend_q) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (tbl_st[i] != ST_EMPTY && tbl_st[i] != ST_STATIC)
                  tbl_st[i] <= tbl_st[i] - 4'd1;
            end
         end
         if (ins_do) begin
            tbl_mac[ins_idx]   <= lrn_mac;
            tbl_ports[ins_idx] <= lrn_ports;
            tbl_st[ins_idx]    <= lrn_static ? ST_STATIC : 4'(NEW_STATUS);
         end
      end
   end

   // registers and command engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q        <= '0;
         busy_q      <= 1'b0;
         port_q      <= '0;
         viol_q      <= 1'b0;
         b4_q        <= '0;
         b5_q        <= '0;
         addr_q      <= '0;
         res_ports_q <= '0;
         res_st_q    <= '0;
         ctrl_q      <= '0;
         idx_q       <= '0;
         passed_q    <= 1'b0;
      end else if (busy_q) begin
         idx_q <= idx_q + IDX_W'(1);
         case (op_q)
            OP_FLUSH_ALL, OP_FLUSH_PORT: begin
               if (last) busy_q <= 1'b0;
            end
            OP_GET_NEXT: begin
               if (e_valid && passed_q) begin
                  addr_q      <= e_mac[47:16];
                  b4_q        <= e_mac[15:8];
                  b5_q        <= e_mac[7:0];
                  res_ports_q <= 5'(e_ports);
                  res_st_q    <= e_st;
                  busy_q      <= 1'b0;
               end else begin
                  if (e_valid && (e_mac == cursor)) passed_q <= 1'b1;
                  if (last) begin
                     res_ports_q <= '0;
                     res_st_q    <= '0;
                     busy_q      <= 1'b0;
                  end
               end
            end
            default: busy_q <= 1'b0;
         endcase
      end else begin
         if (lrn_valid && ins_drop) viol_q <= 1'b1;
         else if (wr_idle && reg_waddr == RA_CMD && reg_wdata[CMD_VIOL_BIT]) viol_q <= 1'b0;
         if (wr_idle) begin
            case (reg_waddr)
               RA_CMD: begin
                  op_q   <= reg_wdata[2:0];
                  busy_q <= reg_wdata[CMD_BUSY_BIT];
                  port_q <= reg_wdata[11:8];
                  b4_q   <= reg_wdata[23:16];
                  b5_q   <= reg_wdata[31:24];
               end
               RA_ADDR:   addr_q <= reg_wdata;
               RA_RESULT: begin
                  res_ports_q <= reg_wdata[4:0];
                  res_st_q    <= reg_wdata[19:16];
               end
               default:   ctrl_q <= reg_wdata & CTL_MASK;
            endcase
         end
         if (start_cmd) begin
            idx_q    <= '0;
            passed_q <= (start_cursor == 48'd0);
         end
      end
   end

   always_comb begin
      case (reg_raddr)
         RA_CMD:    reg_rdata = {b5_q, b4_q, 3'b000, viol_q, port_q, 4'b0000, busy_q, op_q};
         RA_ADDR:   reg_rdata = addr_q;
         RA_RESULT: reg_rdata = {12'd0, res_st_q, 11'd0, res_ports_q};
         default:   reg_rdata = ctrl_q;
      endcase
   end

   // checks beside the logic
   logic [CNT_W-1:0] busy_cnt;
   logic             any_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (busy_q) busy_cnt <= busy_cnt + CNT_W'(1);
      else             busy_cnt <= '0;
   end

   always_comb begin
      any_valid = 1'b0;
      for (int i = 0; i < ENTRIES; i++) any_valid = any_valid | (tbl_st[i] != ST_EMPTY);
   end

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start_cmd |=> busy_q); // R2
   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (busy_cnt < CNT_W'(ENTRIES))); // R2
   AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && reg_we) |=> $stable(ctrl_q)); // R3
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_q) && op_q == OP_FLUSH_ALL) |-> !any_valid); // R7
   AST_END_NO_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_q) && op_q == OP_GET_NEXT && res_st_q == 4'd0) |-> (res_ports_q == 5'd0)); // R5
   AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && lrn_valid && ins_drop) |=> viol_q); // R10

   for (genvar g = 0; g < ENTRIES; g++) begin : g_static_chk
      AST_STATIC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (!busy_q && tbl_st[g] == ST_STATIC && !(ins_do && ins_idx == IDX_W'(g)))
         |=> (tbl_st[g] == ST_STATIC)); // R12
   end
endmodule

// File: tb/test_mac_table_engine.sv
module test_mac_table_engine;
   localparam int N   = 16;
   localparam int NP  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        lrn_valid = 1'b0;
   logic        lrn_ready;
   logic [47:0] lrn_mac = '0;
   logic [NP-1:0] lrn_ports = '0;
   logic        lrn_static = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   // model
   logic [47:0]   m_mac   [N];
   logic [NP-1:0] m_ports [N];
   logic [3:0]    m_st    [N];
   logic          m_viol;
   logic          m_repl;

   always #2 clk = ~clk;

   mac_table_engine i_mac_table_engine (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .lrn_valid(lrn_valid), .lrn_ready(lrn_ready),
      .lrn_mac(lrn_mac), .lrn_ports(lrn_ports), .lrn_static(lrn_static)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog expired act=hung exp=done");
      summary();
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(output int cycles);
      logic [31:0] c;
      cycles = 0;
      for (int k = 0; k < 40; k++) begin
         rd(2'd0, c);
         if (!c[3]) break;
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic learn(input logic [47:0] mac, input logic [NP-1:0] pm, input bit stat);
      int hit, fr, vi;
      logic [3:0] best;
      @(negedge clk);
      lrn_valid = 1'b1; lrn_mac = mac; lrn_ports = pm; lrn_static = stat;
      @(negedge clk);
      lrn_valid = 1'b0;
      hit = -1; fr = -1; vi = -1; best = 4'hF;
      for (int i = 0; i < N; i++) begin
         if (m_st[i] != 0 && m_mac[i] == mac && hit < 0) hit = i;
         if (m_st[i] == 0 && fr < 0) fr = i;
         if (m_st[i] != 0 && m_st[i] != 4'hF && m_st[i] < best) begin best = m_st[i]; vi = i; end
      end
      if (hit < 0) hit = fr;
      if (hit < 0 && m_repl) hit = vi;
      if (hit < 0) m_viol = 1'b1;
      else begin
         m_mac[hit] = mac; m_ports[hit] = pm; m_st[hit] = stat ? 4'hF : 4'd7;
      end
   endtask

   task automatic model_flush_port(input int p);
      for (int i = 0; i < N; i++)
         if (m_st[i] != 0 && !m_mac[i][40] && p < NP && m_ports[i][p]) m_st[i] = 0;
   endtask

   task automatic get_next(output logic [47:0] mac, output logic [4:0] pm, output logic [3:0] st);
      logic [31:0] c, a, r;
      int cy;
      rd(2'd0, c);
      wr(2'd0, {c[31:16], 16'h000E});
      wait_idle(cy);
      rd(2'd0, c); rd(2'd1, a); rd(2'd2, r);
      mac = {a, c[23:16], c[31:24]};
      pm = r[4:0];
      st = r[19:16];
   endtask

   task automatic set_cursor(input logic [47:0] mac);
      wr(2'd1, mac[47:16]);
      wr(2'd0, {mac[7:0], mac[15:8], 16'h0000});
      wr(2'd2, 32'd0);
   endtask

   task automatic walk_check(input string req);
      logic [47:0] mac; logic [4:0] pm; logic [3:0] st;
      set_cursor(48'd0);
      for (int i = 0; i < N; i++) begin
         if (m_st[i] != 0) begin
            get_next(mac, pm, st);
            chk(mac == m_mac[i], req, "walk mac", 64'(mac), 64'(m_mac[i]));
            chk(pm == 5'(m_ports[i]) && st == m_st[i], req, "walk ports/status",
                64'({pm, st}), 64'({5'(m_ports[i]), m_st[i]}));
         end
      end
      get_next(mac, pm, st);
      chk(st == 0 && pm == 0, "R5", "walk end", 64'({pm, st}), 64'd0);
   endtask

   task automatic check_viol();
      logic [31:0] c;
      rd(2'd0, c);
      chk(c[12] == m_viol, "R10", "violation bit", 64'(c[12]), 64'(m_viol));
   endtask

   logic [47:0] rmac;

   initial begin
      logic [31:0] v;
      logic [47:0] mac; logic [4:0] pm; logic [3:0] st;
      int cy;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < N; i++) begin m_mac[i] = '0; m_ports[i] = '0; m_st[i] = '0; end
      m_viol = 0; m_repl = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 0, "R1", "register after reset", 64'(v), 64'd0);
      end
      chk(lrn_ready == 1'b1, "R1", "lrn_ready after reset", 64'(lrn_ready), 64'd1);
      get_next(mac, pm, st);
      chk(st == 0, "R1", "empty table get-next", 64'(st), 64'd0);

      // R13: control register field mask
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, v);
      chk(v == 32'h0016_FFFF, "R13", "control readback", 64'(v), 64'h0016_FFFF);
      wr(2'd3, 32'h0);

      // R4 / R9: directed learns and byte placement
      learn(48'h0211_2233_4455, 5'b00011, 0);
      learn(48'h0A00_0000_0001, 5'b10000, 1);
      learn(48'h0100_5E00_0001, 5'b00100, 0);
      set_cursor(48'd0);
      get_next(mac, pm, st);
      rd(2'd1, v);
      chk(v == 32'h0211_2233, "R4", "address register bytes 0..3", 64'(v), 64'h0211_2233);
      rd(2'd0, v);
      chk(v[31:16] == 16'h5544, "R4", "command bytes 4/5", 64'(v[31:16]), 64'h5544);
      rd(2'd2, v);
      chk(v == 32'h0007_0003, "R4", "result ports/status", 64'(v), 64'h0007_0003);
      get_next(mac, pm, st);
      chk(mac == 48'h0A00_0000_0001 && st == 4'hF, "R5", "second entry static",
          64'({mac, st}), 64'({48'h0A00_0000_0001, 4'hF}));
      learn(48'h0211_2233_4455, 5'b01000, 0);
      walk_check("R9");

      // R6: cursor not in table
      set_cursor(48'h0BAD_0BAD_0BAD);
      get_next(mac, pm, st);
      chk(st == 0 && pm == 0, "R6", "absent cursor", 64'({pm, st}), 64'd0);

      // R2 / R3: full scan with out-of-range port, writes during busy
      wr(2'd0, 32'h0000_0F0B);
      rd(2'd0, v);
      chk(v[3] == 1'b1, "R2", "busy after start", 64'(v[3]), 64'd1);
      chk(lrn_ready == 1'b0, "R3", "lrn_ready while busy", 64'(lrn_ready), 64'd0);
      wr(2'd3, 32'h0000_002B);
      wr(2'd1, 32'hDEAD_BEEF);
      wait_idle(cy);
      chk(cy <= 14, "R2", "busy duration", 64'(cy + 2), 64'd16);
      rd(2'd3, v);
      chk(v == 0, "R3", "control write ignored while busy", 64'(v), 64'd0);
      rd(2'd1, v);
      chk(v != 32'hDEAD_BEEF, "R3", "address write ignored while busy", 64'(v), 64'd0);
      walk_check("R8");

      // R7: flush all
      wr(2'd0, 32'h0000_0009);
      wait_idle(cy);
      for (int i = 0; i < N; i++) m_st[i] = 0;
      walk_check("R7");

      // random rounds: fill, overflow, replace, flush-port
      for (int rnd = 0; rnd < 8; rnd++) begin
         m_repl = rnd[0];
         wr(2'd3, m_repl ? 32'h0004_0000 : 32'h0);
         for (int k = 0; k < 20; k++) begin
            if (k > 3 && ($urandom % 5) == 0) begin
               int j;
               j = $urandom % N;
               rmac = m_mac[j];
               if (rmac == 0) rmac = 48'h0200_0000_0077;
            end else begin
               rmac = {16'($urandom), 32'($urandom)};
               rmac[40] = (($urandom % 4) == 0);
               if (rmac == 0) rmac = 48'h0200_0000_0001;
            end
            learn(rmac, NP'(($urandom % 31) + 1), (($urandom % 6) == 0));
         end
         check_viol();
         walk_check(m_repl ? "R11" : "R10");
         begin
            int p;
            p = $urandom % 6;
            wr(2'd0, {16'h0, 4'h0, 4'(p), 8'h0B});
            wait_idle(cy);
            model_flush_port(p);
         end
         walk_check("R8");
         if (rnd == 3) begin
            wr(2'd0, 32'h0000_1000);
            m_viol = 0;
            check_viol();
         end
      end

      // R11: all static full table, replacement on -> drop
      wr(2'd0, 32'h0000_1009);
      wait_idle(cy);
      for (int i = 0; i < N; i++) m_st[i] = 0;
      m_viol = 0;
      m_repl = 1;
      wr(2'd3, 32'h0004_0000);
      for (int i = 0; i < N; i++) learn({8'h02, 8'(i), 32'h1111_0000}, 5'b00001, 1);
      learn(48'h0200_FFFF_FFFF, 5'b00010, 0);
      check_viol();
      walk_check("R11");

      // R12: aging
      wr(2'd0, 32'h0000_1009);
      wait_idle(cy);
      for (int i = 0; i < N; i++) m_st[i] = 0;
      learn(48'h0200_0000_00AA, 5'b00001, 1);
      learn(48'h0200_0000_00BB, 5'b00010, 0);
      wr(2'd3, 32'h0002_0002);
      repeat (30) @(negedge clk);
      set_cursor(48'h0200_0000_00AA);
      get_next(mac, pm, st);
      chk(mac == 48'h0200_0000_00BB && st > 0 && st < 7, "R12", "dynamic status decreasing",
          64'(st), 64'd4);
      repeat (120) @(negedge clk);
      set_cursor(48'd0);
      get_next(mac, pm, st);
      chk(mac == 48'h0200_0000_00AA && st == 4'hF, "R12", "static survives aging",
          64'({mac, st}), 64'({48'h0200_0000_00AA, 4'hF}));
      get_next(mac, pm, st);
      chk(st == 0, "R12", "dynamic entry expired", 64'(st), 64'd0);
      wr(2'd3, 32'h0);

      summary();
      $finish;
   end
endmodule